// File: doc/BRIEF.md
# Two-Way Slot Mailbox with Pointer Status

This block carries 32-bit slots between a host, which sees a small word-addressed register bus, and a peer processor, which sees two streams. Host-to-peer traffic enters through a write window register and leaves on a valid/ready output stream. Peer-to-host traffic enters on a valid/ready input stream and is dequeued by host reads of a read window register. Each direction keeps its own ring of `2**AW` slots (8 by default) with free-running 8-bit read and write pointers. Software computes occupancy as write pointer minus read pointer, modulo 256.

A host status register holds the host-to-peer ring pointers, the ring depth, interrupt enable, a write-one-to-clear interrupt status, a doorbell toward the peer, a ring reset control and a sticky overflow flag. A peer status register holds the peer-to-host pointers, the depth, an overflow flag and the peer's ready level. The peer raises the host interrupt status with a one-cycle pulse on `peer_db`. The host rings the peer by writing the doorbell bit.

Back-pressure rules: `h2p_valid` is high while the host-to-peer ring holds a slot, and a slot moves on every clock edge where `h2p_valid` and `h2p_ready` are both high. `p2h_ready` is high while the peer-to-host ring has a free slot and the ring reset bit is clear, and a slot is taken on every edge where `p2h_valid` and `p2h_ready` are both high. Offsets are 0x0 write window, 0x4 host status, 0x8 read window and 0xC peer status. Other offsets read as zero and ignore writes.

Top module: `mbx_top`

## Requirements
- R1: The host status register (0x4) reads {depth[31:24], write pointer[23:16], read pointer[15:8], 2'b00, overflow[5], reset[4], 0[3], 0[2], status[1], enable[0]}. After reset it reads 0x08000000 with the default depth of 8.
- R2: A bus write to 0x0 puts the write data in the host-to-peer ring and advances its write pointer by one. `h2p_valid` is high exactly while the ring is non-empty, and `h2p_data` presents slots in the order they were written.
- R3: A write to 0x0 while the host-to-peer ring holds `2**AW` slots is dropped, leaves both pointers unchanged and sets bit 5 of the host status. Bit 5 stays set until bit 4 (reset) is written as 1 or `rst_n` is asserted. The filled count never exceeds the depth.
- R4: A read of 0x8 returns the oldest peer-to-host slot on `bus_rdata` from the following cycle and advances that ring's read pointer. If the ring is empty, the read returns zero and leaves the pointers unchanged.
- R5: The peer status register (0xC) reads {depth[31:24], write pointer[23:16], read pointer[15:8], 2'b00, filled-count-above-depth[5], 0[4], `peer_ready`[3], 3'b000}, with the pointers taken from the peer-to-host ring.
- R6: A `peer_db` pulse sets status bit 1. Writing 1 to bit 1 of 0x4 clears it, and writing 0 leaves it unchanged. When a set and a clear fall in the same cycle, the set wins.
- R7: `irq` is high exactly when status bit 1 and enable bit 0 are both set.
- R8: Writing 0x4 with bit 2 set produces a one-cycle `host_db` pulse in the cycle after the write. Bit 2 always reads 0, and writing it as 0 produces no pulse.
- R9: While bit 4 of 0x4 is 1, both rings have their pointers cleared to zero and hold them there, the sticky overflow clears, writes to 0x0 are ignored and `p2h_ready` is low. Writing bit 4 back to 0 resumes normal operation.
- R10: `p2h_ready` is high exactly while the peer-to-host ring is not full and the ring reset is not set. Slots offered while it is low are not taken.
- R11: Pointers are 8 bits wide, advance by one per slot and wrap from 255 to 0, so the filled count stays write minus read modulo 256 across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data, registered, held until the next read |
| h2p_valid | output | 1 | Host-to-peer slot available |
| h2p_data | output | 32 | Host-to-peer slot at the head |
| h2p_ready | input | 1 | Peer accepts the head slot |
| p2h_valid | input | 1 | Peer offers a slot |
| p2h_data | input | 32 | Offered peer slot |
| p2h_ready | output | 1 | Mailbox accepts the offered slot |
| peer_ready | input | 1 | Peer ready level, shown in the peer status |
| peer_db | input | 1 | Peer doorbell pulse, sets the interrupt status |
| host_db | output | 1 | Doorbell pulse toward the peer |
| irq | output | 1 | Host interrupt |

## Verification
Two collisions matter most. The first is a host write to the write window in the same cycle that the peer pops the head of a full or nearly full ring. The second is a `peer_db` pulse in the same cycle as a write-one-to-clear of the status bit. Random phases drive host writes and peer pops together, and peer pushes and host window reads together. A bench model that applies the full check before the pop, and the pop before the push, decides each cycle's accept, drop and returned data. The doorbell collision is a directed case, and it is judged by `irq` and by the status bit read back afterwards.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [3:0] OFS_WWIN  = 4'h0;
  localparam logic [3:0] OFS_HSTAT = 4'h4;
  localparam logic [3:0] OFS_RWIN  = 4'h8;
  localparam logic [3:0] OFS_PSTAT = 4'hC;

  localparam int B_IE  = 0;
  localparam int B_IS  = 1;
  localparam int B_IG  = 2;
  localparam int B_RDY = 3;
  localparam int B_RST = 4;
  localparam int B_OVF = 5;

  function automatic logic [31:0] pack_stat(logic [7:0] depth, logic [7:0] wp,
                                            logic [7:0] rp, logic [5:0] flags);
    return {depth, wp, rp, 2'b00, flags};
  endfunction
endpackage

// File: rtl/mbx_ring.sv
module mbx_ring #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [7:0]    wptr,
  output logic [7:0]    rptr,
  output logic [7:0]    count,
  output logic          full,
  output logic          over
);
  localparam int         DEPTH  = 1 << AW;
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic do_push, do_pop;

  assign count   = wptr - rptr;
  assign full    = (count >= DEPTH8);
  assign over    = (count > DEPTH8);
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && (count != 8'd0) && !clr;
  assign dout    = mem[rptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (do_push) wptr <= wptr + 8'd1;
      if (do_pop)  rptr <= rptr + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= din;
  end
endmodule

// File: rtl/mbx_hctl.sv
module mbx_hctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stat,
  input  logic w_ie,
  input  logic w_is,
  input  logic w_ig,
  input  logic w_rst,
  input  logic peer_db,
  output logic ie,
  output logic is_bit,
  output logic rst_bit,
  output logic host_db
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie      <= 1'b0;
      is_bit  <= 1'b0;
      rst_bit <= 1'b0;
      host_db <= 1'b0;
    end else begin
      host_db <= wr_stat && w_ig;
      is_bit  <= (is_bit && !(wr_stat && w_is)) || peer_db;
      if (wr_stat) begin
        ie      <= w_ie;
        rst_bit <= w_rst;
      end
    end
  end
endmodule

// File: rtl/mbx_top.sv
module mbx_top #(
  parameter int AW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        h2p_valid,
  output logic [31:0] h2p_data,
  input  logic        h2p_ready,
  input  logic        p2h_valid,
  input  logic [31:0] p2h_data,
  output logic        p2h_ready,
  input  logic        peer_ready,
  input  logic        peer_db,
  output logic        host_db,
  output logic        irq
);
  import mbx_pkg::*;

  localparam int         DEPTH  = 1 << AW;
  localparam logic [7:0] DEPTH8 = 8'(DEPTH);

  logic wr_win, wr_stat, rd_win;
  logic ie, is_bit, rst_bit, ovf_q;
  logic [7:0] h2p_wp, h2p_rp, h2p_cnt, p2h_wp, p2h_rp, p2h_cnt;
  logic h2p_full, h2p_over, p2h_full, p2h_over, p2h_empty;
  logic [31:0] p2h_head, rd_mux;

  assign wr_win  = bus_wr && (bus_addr == OFS_WWIN);
  assign wr_stat = bus_wr && (bus_addr == OFS_HSTAT);
  assign rd_win  = bus_rd && (bus_addr == OFS_RWIN);

  mbx_hctl u_hctl (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat),
    .w_ie(bus_wdata[B_IE]), .w_is(bus_wdata[B_IS]),
    .w_ig(bus_wdata[B_IG]), .w_rst(bus_wdata[B_RST]),
    .peer_db(peer_db), .ie(ie), .is_bit(is_bit),
    .rst_bit(rst_bit), .host_db(host_db)
  );

  mbx_ring #(.DW(32), .AW(AW)) u_h2p (
    .clk(clk), .rst_n(rst_n), .clr(rst_bit),
    .push(wr_win), .din(bus_wdata),
    .pop(h2p_valid && h2p_ready), .dout(h2p_data),
    .wptr(h2p_wp), .rptr(h2p_rp), .count(h2p_cnt),
    .full(h2p_full), .over(h2p_over)
  );

  mbx_ring #(.DW(32), .AW(AW)) u_p2h (
    .clk(clk), .rst_n(rst_n), .clr(rst_bit),
    .push(p2h_valid), .din(p2h_data),
    .pop(rd_win), .dout(p2h_head),
    .wptr(p2h_wp), .rptr(p2h_rp), .count(p2h_cnt),
    .full(p2h_full), .over(p2h_over)
  );

  assign h2p_valid = (h2p_cnt != 8'd0);
  assign p2h_empty = (p2h_cnt == 8'd0);
  assign p2h_ready = !p2h_full && !rst_bit;
  assign irq       = ie && is_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovf_q <= 1'b0;
    else if (rst_bit)               ovf_q <= 1'b0;
    else if (wr_win && h2p_full)    ovf_q <= 1'b1;
  end

  always_comb begin
    unique case (bus_addr)
      OFS_HSTAT: rd_mux = pack_stat(DEPTH8, h2p_wp, h2p_rp,
                   {ovf_q || h2p_over, rst_bit, 1'b0, 1'b0, is_bit, ie});
      OFS_PSTAT: rd_mux = pack_stat(DEPTH8, p2h_wp, p2h_rp,
                   {p2h_over, 1'b0, peer_ready, 3'b000});
      OFS_RWIN:  rd_mux = p2h_empty ? 32'd0 : p2h_head;
      default:   rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mbx_top_chk.sv
module mbx_top_chk #(
  parameter int AW = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        host_db,
  input logic        irq,
  input logic        p2h_ready,
  input logic        peer_db,
  input logic        is_bit,
  input logic        rst_bit,
  input logic        p2h_empty,
  input logic [7:0]  h2p_cnt,
  input logic [7:0]  p2h_cnt
);
  localparam logic [7:0] DEPTH8 = 8'(1 << AW);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    h2p_cnt <= DEPTH8);

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_bit |=> (h2p_cnt == 8'd0 && p2h_cnt == 8'd0));

  a_r8_db_source: assert property (@(posedge clk) disable iff (!rst_n)
    host_db |-> $past(bus_wr && bus_addr == 4'h4 && bus_wdata[2]));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(peer_db) |-> is_bit);

  a_r7_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> is_bit);

  a_r10_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (p2h_cnt == DEPTH8) |-> !p2h_ready);

  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 4'h8 && p2h_empty) |=> (bus_rdata == 32'd0));
endmodule

bind mbx_top mbx_top_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .host_db(host_db), .irq(irq), .p2h_ready(p2h_ready), .peer_db(peer_db),
  .is_bit(is_bit), .rst_bit(rst_bit), .p2h_empty(p2h_empty),
  .h2p_cnt(h2p_cnt), .p2h_cnt(p2h_cnt)
);

// File: tb/mbx_top_bench.sv
module mbx_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic h2p_valid, h2p_ready = 1'b0;
  logic [31:0] h2p_data;
  logic p2h_valid = 1'b0, p2h_ready;
  logic [31:0] p2h_data = '0;
  logic peer_ready = 1'b0, peer_db = 1'b0;
  logic host_db, irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mbx_top u_mbx_top (.*);

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_word(logic [7:0] wp, logic [7:0] rp,
                                            logic [7:0] flags);
    return {8'd8, wp, rp, flags};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  logic [31:0] mq [256];
  logic [31:0] pq [256];

  initial begin
    logic [31:0] v;
    logic [7:0] mwp, mrp, pwp, prp;
    bit movf;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R5 reset state
    rd(4'h4, v); check(v == 32'h0800_0000, "R1 reset hstat", v, 32'h0800_0000);
    rd(4'hC, v); check(v == 32'h0800_0000, "R5 reset pstat", v, 32'h0800_0000);
    peer_ready = 1'b1;
    rd(4'hC, v); check(v == 32'h0800_0008, "R5 ready bit", v, 32'h0800_0008);
    check(irq == 1'b0, "R7 irq idle", {31'd0, irq}, 32'd0);
    check(h2p_valid == 1'b0, "R2 empty valid", {31'd0, h2p_valid}, 32'd0);
    check(p2h_ready == 1'b1, "R10 ready idle", {31'd0, p2h_ready}, 32'd1);

    // R4 empty read
    rd(4'h8, v); check(v == 32'd0, "R4 empty read", v, 32'd0);
    rd(4'hC, v); check(v == 32'h0800_0008, "R4 ptrs unchanged", v, 32'h0800_0008);

    // R2 / R3 fill past full
    for (int i = 0; i < 9; i++) wr(4'h0, 32'hA0 + i);
    rd(4'h4, v); check(v == 32'h0808_0020, "R3 full drop ovf", v, 32'h0808_0020);
    @(negedge clk);
    h2p_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      check(h2p_valid && h2p_data == 32'hA0 + i, "R2 order", h2p_data, 32'hA0 + i);
      @(negedge clk);
    end
    h2p_ready = 1'b0;
    check(h2p_valid == 1'b0, "R3 dropped slot absent", {31'd0, h2p_valid}, 32'd0);
    rd(4'h4, v); check(v == 32'h0808_0820, "R3 sticky", v, 32'h0808_0820);

    // R9 ring reset with doorbell
    wr(4'h4, 32'h14);
    check(host_db == 1'b1, "R8 doorbell pulse", {31'd0, host_db}, 32'd1);
    @(negedge clk);
    check(host_db == 1'b0, "R8 pulse one cycle", {31'd0, host_db}, 32'd0);
    check(p2h_ready == 1'b0, "R9 p2h stalled", {31'd0, p2h_ready}, 32'd0);
    wr(4'h0, 32'hDEAD);
    rd(4'h4, v); check(v == 32'h0800_0010, "R9 cleared", v, 32'h0800_0010);
    wr(4'h4, 32'h0);
    check(host_db == 1'b0, "R8 no pulse", {31'd0, host_db}, 32'd0);
    rd(4'h4, v); check(v == 32'h0800_0000, "R9 released", v, 32'h0800_0000);
    check(h2p_valid == 1'b0, "R9 write ignored", {31'd0, h2p_valid}, 32'd0);

    // R6 / R7 interrupt status
    @(negedge clk); peer_db = 1'b1;
    @(negedge clk); peer_db = 1'b0;
    rd(4'h4, v); check(v == 32'h0800_0002, "R6 status set", v, 32'h0800_0002);
    check(irq == 1'b0, "R7 masked", {31'd0, irq}, 32'd0);
    wr(4'h4, 32'h1);
    check(irq == 1'b1, "R7 enabled", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h1);
    check(irq == 1'b1, "R6 zero keeps", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h3);
    check(irq == 1'b0, "R6 w1c", {31'd0, irq}, 32'd0);
    @(negedge clk);
    bus_addr = 4'h4; bus_wdata = 32'h3; bus_wr = 1'b1; peer_db = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; peer_db = 1'b0;
    check(irq == 1'b1, "R6 set wins", {31'd0, irq}, 32'd1);
    wr(4'h4, 32'h2);
    rd(4'h4, v); check(v == 32'h0800_0000, "R6 cleared", v, 32'h0800_0000);

    // R2 / R3 / R11 random host-to-peer
    mwp = 0; mrp = 0; movf = 0;
    for (int n = 0; n < 1500; n++) begin
      bit dw, rdy;
      logic [31:0] d;
      logic [7:0] cnt;
      dw = ($urandom % 3) != 0;
      rdy = ($urandom % 2) != 0;
      d = $urandom;
      bus_addr = 4'h0; bus_wdata = d; bus_wr = dw; h2p_ready = rdy;
      cnt = mwp - mrp;
      check(h2p_valid == (cnt != 0), "R2 valid", {31'd0, h2p_valid}, {31'd0, cnt != 0});
      if (cnt != 0) check(h2p_data == mq[mrp], "R2 data", h2p_data, mq[mrp]);
      @(negedge clk);
      if (rdy && cnt != 0) mrp = mrp + 8'd1;
      if (dw) begin
        if (cnt < 8) begin mq[mwp] = d; mwp = mwp + 8'd1; end
        else movf = 1;
      end
    end
    bus_wr = 1'b0; h2p_ready = 1'b0;
    rd(4'h4, v);
    check(v == stat_word(mwp, mrp, {2'b00, movf, 5'd0}), "R11 h2p pointers", v,
          stat_word(mwp, mrp, {2'b00, movf, 5'd0}));

    // R4 / R10 / R11 random peer-to-host
    pwp = 0; prp = 0;
    begin
      bit pend = 0;
      logic [31:0] pexp = 0;
      for (int n = 0; n < 1500; n++) begin
        bit pv, hr;
        logic [31:0] d;
        logic [7:0] cnt;
        if (pend) check(bus_rdata == pexp, "R4 window data", bus_rdata, pexp);
        pv = ($urandom % 3) != 0;
        hr = ($urandom % 2) != 0;
        d = $urandom;
        p2h_valid = pv; p2h_data = d; bus_addr = 4'h8; bus_rd = hr;
        cnt = pwp - prp;
        check(p2h_ready == (cnt < 8), "R10 ready", {31'd0, p2h_ready}, {31'd0, cnt < 8});
        pend = hr;
        if (hr) pexp = (cnt != 0) ? pq[prp] : 32'd0;
        @(negedge clk);
        if (hr && cnt != 0) prp = prp + 8'd1;
        if (pv && cnt < 8) begin pq[pwp] = d; pwp = pwp + 8'd1; end
      end
      bus_rd = 1'b0; p2h_valid = 1'b0;
      if (pend) check(bus_rdata == pexp, "R4 window data", bus_rdata, pexp);
    end
    rd(4'hC, v);
    check(v == stat_word(pwp, prp, 8'h08), "R11 p2h pointers", v,
          stat_word(pwp, prp, 8'h08));
    finish_run();
  end
endmodule